// File: doc/BRIEF.md
# Word-Parallel CRC-16 with Partial Last Word

This block computes a 16-bit cyclic redundancy checksum over a byte-oriented stream that arrives as one 32-bit word per clock. Its job is to recompute the checksum of a configuration bitstream that has been edited in flight, so that the new value is ready when the final word of the frame has passed and can be spliced into the outgoing stream.

Every full word is absorbed in one cycle by a combinational 32-bit update network. A frame need not be a whole number of words. The last word may carry one, two or three valid bytes, and it is absorbed in that same single cycle by an 8-, 16- or 24-bit update network chosen by the byte count. A one-cycle done pulse follows the final word. The checksum output then holds its value until the next frame starts.

Top module: `crc16_ragged`

## Requirements
- R1: While `rst` is high at a rising clock edge, `crc_out` becomes 0x0000 and `crc_done` becomes 0.
- R2: The checksum uses generator 0x8005 (x^16+x^15+x^2+1). The register is zero at frame start and has no final inversion and no output reversal. Each data bit d is absorbed as fb = crc[15]^d, then crc = {crc[14:0],0} ^ (fb ? 0x8005 : 0). Within each byte, the bits are absorbed least significant bit first.
- R3: A full word is absorbed in one clock. Byte 0 sits at `in_data[7:0]` and is absorbed first, followed by bytes 1, 2 and 3 in the higher lanes.
- R4: On the word with `in_last` high, `in_nbytes` gives the number of valid bytes: 1, 2 or 3, with 0 meaning all 4. The valid bytes sit in the low lanes. The upper lanes are ignored, and the partial word is absorbed in that same single clock.
- R5: `crc_done` is high for exactly the one cycle after the edge that absorbs the final word. In that cycle, `crc_out` already holds the finished checksum.
- R6: `crc_out` changes only at an edge where a frame word is absorbed. Idle cycles inside a frame and cycles after the frame leave it unchanged.
- R7: Words presented with `in_valid` high outside a frame, without `sof`, are ignored. They change neither `crc_out` nor `crc_done`.
- R8: `sof` counts only together with `in_valid`. It restarts the checksum from zero on that word, even in the middle of an unfinished frame. It may coincide with `in_last` to form a single-word frame.
- R9: A new frame may start on the cycle right after the final word of the previous frame, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | First word of a frame (qualified by in_valid) |
| in_valid | input | 1 | Data word present |
| in_data | input | 32 | Data word, byte 0 in bits [7:0] |
| in_last | input | 1 | Final word of the frame |
| in_nbytes | input | 2 | Valid bytes in the final word, 0 means 4 |
| crc_out | output | 16 | Running checksum |
| crc_done | output | 1 | One-cycle pulse after the final word |

## Verification
Two functions can land on the same clock edge. The first is frame start together with frame end: one word carries both `sof` and `in_last`, so a new checksum is seeded and finished in the same cycle. The second is the done pulse of one frame together with the first word of the next, when frames are sent back to back. Both cases are driven as directed scenarios, including single-word frames of every byte count. Each result is judged against a bit-serial reference computed in the bench, and the bench also confirms that the done pulse drops after one cycle even when the next frame has already begun.

// File: rtl/crc16_ragged_pkg.sv
package crc16_ragged_pkg;

  localparam int CRC_W = 16;
  typedef logic [CRC_W-1:0] crc16_t;
  localparam crc16_t CRC16_POLY = 16'h8005;

  // One bit of the shift-left register update
  function automatic crc16_t crc16_bit(input crc16_t c, input logic d, input crc16_t poly);
    logic fb;
    fb = c[CRC_W-1] ^ d;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

endpackage

// File: rtl/crc_lane_update.sv
module crc_lane_update
  import crc16_ragged_pkg::*;
#(
  parameter int     NBITS = 32,
  parameter crc16_t POLY  = CRC16_POLY
) (
  input  crc16_t           crc_in,
  input  logic [NBITS-1:0] data,
  output crc16_t           crc_out
);

  // Unrolled into an XOR network; bit 0 (byte 0, LSB) enters first
  always_comb begin
    crc16_t acc;
    acc = crc_in;
    for (int i = 0; i < NBITS; i++) begin
      acc = crc16_bit(acc, data[i], POLY);
    end
    crc_out = acc;
  end

endmodule

// File: rtl/crc_width_sel.sv
module crc_width_sel
  import crc16_ragged_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(LANES)
) (
  input  logic                  last,
  input  logic [CNT_W-1:0]      nbytes,
  input  crc16_t [LANES-1:0]    cand,
  output crc16_t                sel
);

  logic partial;
  assign partial = last && (nbytes != '0);

  always_comb begin
    sel = cand[LANES-1];
    if (partial) begin
      for (int k = 1; k < LANES; k++) begin
        if (int'(nbytes) == k) sel = cand[k-1];
      end
    end
  end

endmodule

// File: rtl/crc16_ragged.sv
module crc16_ragged
  import crc16_ragged_pkg::*;
#(
  parameter int     DATA_W = 32,
  parameter crc16_t POLY   = CRC16_POLY,
  localparam int    LANES  = DATA_W / 8,
  localparam int    CNT_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic [CNT_W-1:0]  in_nbytes,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_done
);

  logic               in_frame_q;
  crc16_t             crc_q;
  logic               done_q;
  logic               take;
  crc16_t             base;
  crc16_t [LANES-1:0] cand;
  crc16_t             crc_next;

  assign take = in_valid && (sof || in_frame_q);
  assign base = sof ? '0 : crc_q;

  // One update network per possible byte count of a word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    crc_lane_update #(
      .NBITS (8 * (g + 1)),
      .POLY  (POLY)
    ) u_upd (
      .crc_in  (base),
      .data    (in_data[8*(g+1)-1:0]),
      .crc_out (cand[g])
    );
  end

  crc_width_sel #(
    .LANES (LANES)
  ) u_sel (
    .last   (in_last),
    .nbytes (in_nbytes),
    .cand   (cand),
    .sel    (crc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q      <= '0;
      done_q     <= 1'b0;
      in_frame_q <= 1'b0;
    end else begin
      done_q <= take && in_last;
      if (take) begin
        crc_q      <= crc_next;
        in_frame_q <= !in_last;
      end
    end
  end

  assign crc_out  = crc_q;
  assign crc_done = done_q;

endmodule

// File: rtl/crc16_ragged_chk.sv
module crc16_ragged_chk (
  input logic        clk,
  input logic        rst,
  input logic        sof,
  input logic        in_valid,
  input logic        in_last,
  input logic        in_frame,
  input logic [15:0] crc_out,
  input logic        crc_done
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (crc_out == 16'h0000 && !crc_done)); // R1

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last && (sof || in_frame)) |=> crc_done); // R5

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    crc_done |-> $past(in_valid && in_last)); // R5

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(crc_out)); // R6

  AST_IGNORE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sof && !in_frame) |=> ($stable(crc_out) && !crc_done)); // R7

endmodule

bind crc16_ragged crc16_ragged_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sof      (sof),
  .in_valid (in_valid),
  .in_last  (in_last),
  .in_frame (in_frame_q),
  .crc_out  (crc_out),
  .crc_done (crc_done)
);

// File: tb/crc16_ragged_tb.sv
`timescale 1ns/1ps
module crc16_ragged_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        sof;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_last;
  logic [1:0]  in_nbytes;
  logic [15:0] crc_out;
  logic        crc_done;

  int checks   = 0;
  int failures = 0;
  logic [7:0] bytes_q [0:63];

  always #10 clk = ~clk;

  crc16_ragged u_dut (
    .clk       (clk),
    .rst       (rst),
    .sof       (sof),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_nbytes (in_nbytes),
    .crc_out   (crc_out),
    .crc_done  (crc_done)
  );

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c;
    logic fb;
    c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        fb = c[15] ^ bytes_q[i][b];
        c  = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
      end
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) bytes_q[i] = 8'($urandom);
  endtask

  task automatic drive_idle();
    sof = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_nbytes = 2'd0;
    in_data = $urandom;
  endtask

  // Called at a negedge; returns at the negedge after the final word
  task automatic send_frame(input int n, input int gap, input string tag);
    int nw;
    nw = (n + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      sof      = (w == 0);
      in_valid = 1'b1;
      in_last  = (w == nw - 1);
      in_nbytes = (w == nw - 1) ? 2'(n % 4) : 2'd0;
      for (int j = 0; j < 4; j++) begin
        in_data[8*j +: 8] = (4*w + j < n) ? bytes_q[4*w + j] : 8'($urandom);
      end
      @(negedge clk);
      if (w == 0 && nw > 1) chk("R5 done low mid-frame", 32'(crc_done), 32'd0);
      if (w != nw - 1 && gap > 0) begin
        drive_idle();
        repeat (gap) @(negedge clk);
      end
    end
    chk({tag, " done pulse R5"}, 32'(crc_done), 32'd1);
    chk({tag, " checksum"}, 32'(crc_out), 32'(ref_crc(n)));
    drive_idle();
  endtask

  task automatic t_reset();
    chk("R1 crc after reset", 32'(crc_out), 32'd0);
    chk("R1 done after reset", 32'(crc_done), 32'd0);
  endtask

  task automatic t_full_words();
    fill(4);  send_frame(4, 0, "R2 R3 one word");
    fill(16); send_frame(16, 0, "R2 R3 four words");
    fill(32); send_frame(32, 1, "R3 eight words");
    @(negedge clk);
  endtask

  task automatic t_ragged();
    for (int n = 1; n <= 7; n++) begin
      fill(n);
      send_frame(n, 0, "R4 partial last");
      @(negedge clk);
    end
  endtask

  task automatic t_hold();
    logic [15:0] held;
    fill(9);
    send_frame(9, 2, "R6 gapped frame");
    held = crc_out;
    repeat (3) @(negedge clk);
    chk("R6 crc held", 32'(crc_out), 32'(held));
    chk("R5 done single pulse", 32'(crc_done), 32'd0);
  endtask

  task automatic t_outside();
    logic [15:0] held;
    held = crc_out;
    sof = 1'b0; in_valid = 1'b1; in_last = 1'b0; in_data = 32'hDEADBEEF;
    @(negedge clk);
    in_last = 1'b1; in_nbytes = 2'd2; in_data = 32'h12345678;
    @(negedge clk);
    drive_idle();
    @(negedge clk);
    chk("R7 crc unchanged", 32'(crc_out), 32'(held));
    chk("R7 no done", 32'(crc_done), 32'd0);
  endtask

  task automatic t_restart();
    sof = 1'b1; in_valid = 1'b1; in_last = 1'b0; in_data = 32'hA5A5_0F0F;
    @(negedge clk);
    sof = 1'b0; in_data = 32'h1111_2222;
    @(negedge clk);
    // sof without valid must not count
    sof = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    fill(6);
    send_frame(6, 0, "R8 restart mid-frame");
    for (int n = 1; n <= 4; n++) begin
      fill(n);
      send_frame(n, 0, "R8 single-word frame");
    end
    @(negedge clk);
  endtask

  task automatic t_back_to_back();
    fill(7);
    send_frame(7, 0, "R9 first frame");
    fill(10);
    send_frame(10, 0, "R9 second frame");
    fill(3);
    send_frame(3, 0, "R9 third frame");
    @(negedge clk);
    chk("R9 done dropped", 32'(crc_done), 32'd0);
  endtask

  task automatic t_random();
    for (int i = 0; i < 16; i++) begin
      int n;
      n = 4 * int'($urandom % 10) + (i % 4) + 1;
      fill(n);
      send_frame(n, int'($urandom % 2), "R4 random length");
      if ($urandom % 2) @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive_idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full_words();
    t_ragged();
    t_hold();
    t_outside();
    t_restart();
    t_back_to_back();
    t_random();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule